// File: doc/BRIEF.md
# Core Idle Ladder Controller

This block steps one processor core down and back up a ladder of idle depths. A request names a target depth. The controller then runs, one handshake at a time, the actions that separate the present depth from the target. Going deeper, each level adds one more measure: a halted core on a slow clock, then a slower clock, then the slowest clock with the cache flushed, and finally the architectural state saved to memory and the core's supply gated off. Going shallower, the completed actions are undone in reverse order.

Each action is a request/done handshake with an external agent: the clock generator, the cache, the state-save engine or the power-gate sequencer. The supply rail selection follows the clock code, so a reduced frequency always runs on the low rail. A wake event brings the core back to full activity. If the wake arrives during entry, the handshake in flight completes first, and then only the completed actions are unwound. Every handshake is guarded by a programmable cycle limit. When the limit expires, the controller raises an error and snaps back to the active state.

Top module: `idle_ladder_ctrl`

## Requirements
- R1: After reset the core is active: `cur_level` is 0, `clk_halt`, `clk_code`, `volt_low`, `hs_error` and `busy` are 0, and no handshake request is raised.
- R2: Level codes are 0 (active) to 4 (deepest). Entering level 4 from level 0 issues these handshakes in this order: a clock request with `clk_code` 1 (with `clk_halt` raised alongside it), a clock request with code 2, a clock request with code 3, a cache flush, a state save, and a power-gate sleep. Level 1 is reached after the first action, level 2 after the second, level 3 after the flush, and level 4 after the sleep. Entry from level a to level b runs only the actions that lie between the two levels.
- R3: While the core is settled, level 0 shows clock code 0 with halt low, level 1 shows code 1, level 2 shows code 2, and levels 3 and 4 show code 3, with halt high at every level above 0.
- R4: Exit runs the completed actions in reverse: power-gate wake, state restore, a clock request with code 2, one with code 1, and one with code 0. The flush has no undo step. `clk_halt` falls only after the code-0 clock handshake completes.
- R5: `volt_low` is 1 exactly when `clk_code` is nonzero.
- R6: At most one handshake request is raised at any time.
- R7: A wake event during entry lets the handshake in flight finish. The controller then unwinds exactly the actions completed so far, back to level 0.
- R8: A requested level above `MAX_LEVEL` (default 4) is treated as `MAX_LEVEL`.
- R9: A request for the current level is ignored: no handshake is issued and the level is unchanged.
- R10: A request that arrives while a sequence is running is ignored.
- R11: If a handshake stays undone for `hs_limit`+1 cycles, `hs_error` is set. In the next cycle all requests drop, halt and clock code return to 0, and the level is 0. The flag clears when a later request is accepted.
- R12: A wake event and a request in the same cycle: the wake wins and the core returns to level 0. A wake at level 0 has no effect.
- R13: A request for a shallower nonzero level unwinds only down to that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req_vld | input | 1 | Strobe for a new target level |
| idle_req_lvl | input | 3 | Requested level, 0 to 7 |
| wake_evt | input | 1 | Wake event, return to level 0 |
| hs_limit | input | TW | Handshake timeout in cycles |
| clk_halt | output | 1 | Core halt to the clock generator |
| clk_code | output | 2 | Frequency code, 0 full to 3 slowest |
| clk_req | output | 1 | Clock change request |
| clk_done | input | 1 | Clock change complete |
| volt_low | output | 1 | Select low supply rail |
| flush_req | output | 1 | Cache flush request |
| flush_done | input | 1 | Cache flush complete |
| save_req | output | 1 | State save request |
| restore_req | output | 1 | State restore request |
| save_done | input | 1 | Save or restore complete |
| pg_sleep_req | output | 1 | Power-gate turn-off request |
| pg_wake_req | output | 1 | Power-gate turn-on request |
| pg_done | input | 1 | Power-gate sequence complete |
| cur_level | output | 3 | Current settled depth |
| busy | output | 1 | A sequence is in progress |
| hs_error | output | 1 | Sticky handshake timeout flag |

## Verification
Two collisions matter here. The first is a wake event landing in the same cycle as a new request. The bench provokes it by driving both strobes on one edge from level 2, and judges it by the logged handshake order (code 1, then code 0) and a final level of 0. The second is a wake landing while an entry handshake is still in flight. The bench raises the wake while the flush, or the first clock step, is pending. It then checks that the pending action is logged as finished before the reverse actions, and that no later entry action appears.

// File: rtl/idle_ladder_pkg.sv
package idle_ladder_pkg;

   localparam int LVL_W = 3;
   localparam int POS_W = 3;

   typedef enum logic [0:0] {ST_IDLE, ST_WAIT} st_t;

   typedef enum logic [2:0] {
      CH_NONE, CH_CLK, CH_FLUSH, CH_SAVE, CH_RESTORE, CH_SLEEP, CH_WAKE
   } ch_t;

   // number of completed ladder actions needed for a level
   function automatic logic [POS_W-1:0] lvl_to_pos(input logic [LVL_W-1:0] l);
      case (l)
         3'd0:    return 3'd0;
         3'd1:    return 3'd1;
         3'd2:    return 3'd2;
         3'd3:    return 3'd4;
         default: return 3'd6;
      endcase
   endfunction

   // deepest level fully reached after a number of actions
   function automatic logic [LVL_W-1:0] pos_to_lvl(input logic [POS_W-1:0] p);
      case (p)
         3'd0:        return 3'd0;
         3'd1:        return 3'd1;
         3'd2, 3'd3:  return 3'd2;
         3'd4, 3'd5:  return 3'd3;
         default:     return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/idle_req_clamp.sv
module idle_req_clamp
   import idle_ladder_pkg::*;
#(
   parameter int MAX_LEVEL = 4
) (
   input  logic [LVL_W-1:0] lvl_i,
   output logic [LVL_W-1:0] lvl_o
);

   localparam logic [LVL_W-1:0] MAX_L = LVL_W'(MAX_LEVEL);

   generate
      if (MAX_LEVEL < 1 || MAX_LEVEL > 4) begin : g_bad_max
         $error("idle_req_clamp: MAX_LEVEL must lie in 1..4");
      end
      if (MAX_LEVEL == (1 << LVL_W) - 1) begin : g_pass
         assign lvl_o = lvl_i;
      end else begin : g_sat
         assign lvl_o = (lvl_i > MAX_L) ? MAX_L : lvl_i;
      end
   endgenerate

endmodule

// File: rtl/idle_hs_timer.sv
module idle_hs_timer #(
   parameter int TW     = 8,
   parameter bit TMO_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [TW-1:0] limit,
   output logic          expired
);

   generate
      if (TW < 2) begin : g_bad_tw
         $error("idle_hs_timer: TW must be at least 2");
      end
      if (TMO_EN) begin : g_cnt
         logic [TW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (!run)         cnt <= '0;
            else if (cnt != limit) cnt <= cnt + 1'b1;
         end

         assign expired = run && (cnt == limit);

         p_cnt_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> (cnt == '0));
      end else begin : g_off
         assign expired = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
   import idle_ladder_pkg::*;
#(
   parameter int MAX_LEVEL = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [LVL_W-1:0] req_lvl,
   input  logic             wake,
   input  logic             expired,
   input  logic             clk_done,
   input  logic             flush_done,
   input  logic             sv_done,
   input  logic             pg_done,
   output logic             in_wait,
   output logic             halt,
   output logic [1:0]       clk_code,
   output logic             clk_req,
   output logic             flush_req,
   output logic             save_req,
   output logic             restore_req,
   output logic             pg_sleep,
   output logic             pg_wake,
   output logic [LVL_W-1:0] level,
   output logic             busy,
   output logic             err
);

   st_t              st;
   ch_t              ch;
   logic [POS_W-1:0] pos, tgt, tgt_eff;
   logic             wake_pend, wake_any, settled, accept, done_sel;

   assign settled  = (pos == tgt);
   assign wake_any = wake | wake_pend;
   assign accept   = settled && req_valid && !wake_any && (req_lvl != pos_to_lvl(pos));
   assign tgt_eff  = wake_any ? '0 : (accept ? lvl_to_pos(req_lvl) : tgt);

   always_comb begin
      case (ch)
         CH_CLK:                done_sel = clk_done;
         CH_FLUSH:              done_sel = flush_done;
         CH_SAVE, CH_RESTORE:   done_sel = sv_done;
         CH_SLEEP, CH_WAKE:     done_sel = pg_done;
         default:               done_sel = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; ch <= CH_NONE; pos <= '0; tgt <= '0;
         wake_pend <= 1'b0; err <= 1'b0; halt <= 1'b0; clk_code <= 2'd0;
      end else if (st == ST_IDLE) begin
         tgt       <= tgt_eff;
         wake_pend <= 1'b0;
         if (accept) err <= 1'b0;
         if (pos < tgt_eff) begin
            st <= ST_WAIT;
            case (pos)
               3'd0:    begin halt <= 1'b1; clk_code <= 2'd1; ch <= CH_CLK; end
               3'd1:    begin clk_code <= 2'd2; ch <= CH_CLK; end
               3'd2:    begin clk_code <= 2'd3; ch <= CH_CLK; end
               3'd3:    ch <= CH_FLUSH;
               3'd4:    ch <= CH_SAVE;
               default: ch <= CH_SLEEP;
            endcase
         end else if (pos > tgt_eff) begin
            case (pos)
               3'd6:    begin st <= ST_WAIT; ch <= CH_WAKE; end
               3'd5:    begin st <= ST_WAIT; ch <= CH_RESTORE; end
               3'd4:    pos <= 3'd3;
               3'd3:    begin st <= ST_WAIT; clk_code <= 2'd2; ch <= CH_CLK; end
               3'd2:    begin st <= ST_WAIT; clk_code <= 2'd1; ch <= CH_CLK; end
               default: begin st <= ST_WAIT; clk_code <= 2'd0; ch <= CH_CLK; end
            endcase
         end
      end else begin
         if (wake) wake_pend <= 1'b1;
         if (done_sel) begin
            st <= ST_IDLE;
            ch <= CH_NONE;
            if (pos < tgt) pos <= pos + 1'b1;
            else begin
               pos <= pos - 1'b1;
               if (pos == 3'd1) halt <= 1'b0;
            end
         end else if (expired) begin
            st <= ST_IDLE; ch <= CH_NONE; pos <= '0; tgt <= '0;
            wake_pend <= 1'b0; err <= 1'b1; halt <= 1'b0; clk_code <= 2'd0;
         end
      end
   end

   assign in_wait     = (st == ST_WAIT);
   assign clk_req     = in_wait && (ch == CH_CLK);
   assign flush_req   = in_wait && (ch == CH_FLUSH);
   assign save_req    = in_wait && (ch == CH_SAVE);
   assign restore_req = in_wait && (ch == CH_RESTORE);
   assign pg_sleep    = in_wait && (ch == CH_SLEEP);
   assign pg_wake     = in_wait && (ch == CH_WAKE);
   assign level       = pos_to_lvl(pos);
   assign busy        = in_wait || !settled;

   p_one_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({clk_req, flush_req, save_req, restore_req, pg_sleep, pg_wake}));

   p_tmo_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait && expired && !done_sel) |=> (err && level == '0 && !halt && clk_code == 2'd0));

   p_slow_halted_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_code != 2'd0) |-> halt);

   p_save_slowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
      save_req |-> (clk_code == 2'd3 && halt));

   p_same_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_wait && settled && req_valid && !wake && req_lvl == level) |=> (!in_wait && $stable(level)));

   p_wake_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_wait && wake) |=> (tgt == '0));

   p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_lvl <= LVL_W'(MAX_LEVEL)));

endmodule

// File: rtl/idle_ladder_ctrl.sv
module idle_ladder_ctrl
   import idle_ladder_pkg::*;
#(
   parameter int MAX_LEVEL = 4,
   parameter int TW        = 8,
   parameter bit TMO_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle_req_vld,
   input  logic [LVL_W-1:0] idle_req_lvl,
   input  logic             wake_evt,
   input  logic [TW-1:0]    hs_limit,
   output logic             clk_halt,
   output logic [1:0]       clk_code,
   output logic             clk_req,
   input  logic             clk_done,
   output logic             volt_low,
   output logic             flush_req,
   input  logic             flush_done,
   output logic             save_req,
   output logic             restore_req,
   input  logic             save_done,
   output logic             pg_sleep_req,
   output logic             pg_wake_req,
   input  logic             pg_done,
   output logic [LVL_W-1:0] cur_level,
   output logic             busy,
   output logic             hs_error
);

   logic [LVL_W-1:0] lvl_sat;
   logic             in_wait, expired;

   idle_req_clamp #(.MAX_LEVEL(MAX_LEVEL)) u_clamp (
      .lvl_i (idle_req_lvl),
      .lvl_o (lvl_sat)
   );

   idle_hs_timer #(.TW(TW), .TMO_EN(TMO_EN)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (in_wait),
      .limit   (hs_limit),
      .expired (expired)
   );

   idle_seq_fsm #(.MAX_LEVEL(MAX_LEVEL)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (idle_req_vld),
      .req_lvl     (lvl_sat),
      .wake        (wake_evt),
      .expired     (expired),
      .clk_done    (clk_done),
      .flush_done  (flush_done),
      .sv_done     (save_done),
      .pg_done     (pg_done),
      .in_wait     (in_wait),
      .halt        (clk_halt),
      .clk_code    (clk_code),
      .clk_req     (clk_req),
      .flush_req   (flush_req),
      .save_req    (save_req),
      .restore_req (restore_req),
      .pg_sleep    (pg_sleep_req),
      .pg_wake     (pg_wake_req),
      .level       (cur_level),
      .busy        (busy),
      .err         (hs_error)
   );

   // rail follows frequency: any reduced clock runs on the low rail
   assign volt_low = (clk_code != 2'd0);

   p_rail_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_level == '0 && !busy) |-> !volt_low);

endmodule

// File: tb/idle_ladder_ctrl_test.sv
module idle_ladder_ctrl_test;

   localparam int TW  = 8;
   localparam int LIM = 20;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, idle_req_vld, wake_evt;
   logic [2:0]    idle_req_lvl;
   logic [TW-1:0] hs_limit;
   logic          clk_halt, clk_req, clk_done, volt_low, flush_req, flush_done;
   logic          save_req, restore_req, save_done, pg_sleep_req, pg_wake_req, pg_done;
   logic [1:0]    clk_code;
   logic [2:0]    cur_level;
   logic          busy, hs_error;

   idle_ladder_ctrl #(.MAX_LEVEL(4), .TW(TW), .TMO_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .idle_req_vld(idle_req_vld), .idle_req_lvl(idle_req_lvl),
      .wake_evt(wake_evt), .hs_limit(hs_limit), .clk_halt(clk_halt), .clk_code(clk_code),
      .clk_req(clk_req), .clk_done(clk_done), .volt_low(volt_low), .flush_req(flush_req),
      .flush_done(flush_done), .save_req(save_req), .restore_req(restore_req),
      .save_done(save_done), .pg_sleep_req(pg_sleep_req), .pg_wake_req(pg_wake_req),
      .pg_done(pg_done), .cur_level(cur_level), .busy(busy), .hs_error(hs_error)
   );

   // responder models: done rises a set number of cycles after the request
   int dly_clk = 3, dly_fl = 3, dly_sv = 3, dly_pg = 2;
   int c_clk = 0, c_fl = 0, c_sv = 0, c_pg = 0;
   always @(posedge clk) begin
      c_clk <= clk_req ? c_clk + 1 : 0;
      c_fl  <= flush_req ? c_fl + 1 : 0;
      c_sv  <= (save_req | restore_req) ? c_sv + 1 : 0;
      c_pg  <= (pg_sleep_req | pg_wake_req) ? c_pg + 1 : 0;
   end
   assign clk_done   = clk_req && (c_clk >= dly_clk);
   assign flush_done = flush_req && (c_fl >= dly_fl);
   assign save_done  = (save_req | restore_req) && (c_sv >= dly_sv);
   assign pg_done    = (pg_sleep_req | pg_wake_req) && (c_pg >= dly_pg);

   // event log of request rising edges
   // codes: 10+clock code, 20 flush, 30 save, 40 restore, 50 sleep, 60 wake
   int ev [0:63];
   int nev = 0;
   int overlap = 0;
   logic p_clk = 0, p_fl = 0, p_sv = 0, p_rs = 0, p_sl = 0, p_wk = 0;

   task automatic push(input int v);
      if (nev < 64) ev[nev] = v;
      nev++;
   endtask

   always @(negedge clk) begin
      if (clk_req && !p_clk)      push(10 + int'(clk_code));
      if (flush_req && !p_fl)     push(20);
      if (save_req && !p_sv)      push(30);
      if (restore_req && !p_rs)   push(40);
      if (pg_sleep_req && !p_sl)  push(50);
      if (pg_wake_req && !p_wk)   push(60);
      if ($countones({clk_req, flush_req, save_req, restore_req, pg_sleep_req, pg_wake_req}) > 1)
         overlap++;
      p_clk = clk_req; p_fl = flush_req; p_sv = save_req;
      p_rs = restore_req; p_sl = pg_sleep_req; p_wk = pg_wake_req;
   end

   int nchk = 0, nerr = 0;

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   function automatic int pos_of(input int l);
      case (l)
         0: return 0;
         1: return 1;
         2: return 2;
         3: return 4;
         default: return 6;
      endcase
   endfunction

   function automatic int ent_ev(input int k);
      case (k)
         1: return 11;
         2: return 12;
         3: return 13;
         4: return 20;
         5: return 30;
         default: return 50;
      endcase
   endfunction

   function automatic int ext_ev(input int k);
      case (k)
         6: return 60;
         5: return 40;
         4: return -1;
         3: return 12;
         2: return 11;
         default: return 10;
      endcase
   endfunction

   function automatic int code_of(input int l);
      return (l > 3) ? 3 : l;
   endfunction

   int xp [0:15];
   int nxp = 0;

   task automatic build_exp(input int pa, input int pb);
      nxp = 0;
      if (pa < pb) begin
         for (int k = pa + 1; k <= pb; k++) begin xp[nxp] = ent_ev(k); nxp++; end
      end else begin
         for (int k = pa; k > pb; k--) begin
            if (ext_ev(k) >= 0) begin xp[nxp] = ext_ev(k); nxp++; end
         end
      end
   endtask

   task automatic add_exp(input int v);
      xp[nxp] = v; nxp++;
   endtask

   task automatic cmp_log(input string rq);
      int bad;
      bad = -1;
      chk(nev == nxp, rq, "handshake count", nev, nxp);
      if (nev == nxp)
         for (int i = 0; i < nxp; i++) if (bad < 0 && ev[i] != xp[i]) bad = i;
      if (bad >= 0) chk(1'b0, rq, "handshake order entry", ev[bad], xp[bad]);
      else          chk(1'b1, rq, "handshake order", 0, 0);
   endtask

   task automatic settle();
      int g;
      g = 0;
      while (busy && g < 3000) begin @(negedge clk); g++; end
      chk(g < 3000, "R2", "sequence did not settle", g, 0);
   endtask

   task automatic do_req(input int l);
      @(negedge clk);
      idle_req_vld = 1'b1; idle_req_lvl = 3'(l);
      @(negedge clk);
      idle_req_vld = 1'b0;
   endtask

   task automatic wake_pulse();
      @(negedge clk); wake_evt = 1'b1;
      @(negedge clk); wake_evt = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
   endtask

   initial begin
      #(4 * 190000);
      nerr++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      int te;
      string tag;
      rst_n = 1'b0; idle_req_vld = 1'b0; idle_req_lvl = '0; wake_evt = 1'b0;
      hs_limit = TW'(LIM);
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(cur_level == 0 && !busy, "R1", "level/busy in reset", int'(cur_level), 0);
      chk(!clk_halt && clk_code == 0 && !volt_low && !hs_error, "R1", "halt/code/rail/err", int'(clk_code), 0);
      chk({clk_req, flush_req, save_req, restore_req, pg_sleep_req, pg_wake_req} == 0, "R1", "requests",
          int'({clk_req, flush_req, save_req, restore_req, pg_sleep_req, pg_wake_req}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(cur_level == 0 && !busy && !clk_halt, "R1", "after release", int'(cur_level), 0);

      // sweep every start level against every request code
      for (int f = 0; f <= 4; f++) begin
         for (int t = 0; t <= 7; t++) begin
            if (f > 0) begin do_req(f); settle(); end
            nev = 0;
            do_req(t); settle();
            te = (t > 4) ? 4 : t;
            if (t > 4)       tag = "R8";
            else if (t == f) tag = "R9";
            else if (t > f)  tag = "R2";
            else if (t > 0)  tag = "R13";
            else             tag = "R4";
            build_exp(pos_of(f), pos_of(te));
            cmp_log(tag);
            chk(int'(cur_level) == te, tag, "settled level", int'(cur_level), te);
            chk(clk_halt == (te > 0), "R3", "halt at level", int'(clk_halt), int'(te > 0));
            chk(int'(clk_code) == code_of(te), "R3", "clock code at level", int'(clk_code), code_of(te));
            chk(volt_low == (code_of(te) != 0), "R5", "rail vs clock code", int'(volt_low), int'(code_of(te) != 0));
            if (te > 0) begin
               nev = 0;
               wake_pulse(); settle();
               build_exp(pos_of(te), 0);
               cmp_log("R4");
            end
            chk(cur_level == 0 && !clk_halt, "R4", "back to active", int'(cur_level), 0);
         end
      end

      // R12 wake at level 0 does nothing
      nev = 0;
      wake_pulse();
      repeat (3) @(negedge clk);
      chk(nev == 0 && !busy && cur_level == 0, "R12", "wake at level 0 events", nev, 0);

      // R12 wake and request together from level 2
      do_req(2); settle();
      nev = 0;
      @(negedge clk); idle_req_vld = 1'b1; idle_req_lvl = 3'd4; wake_evt = 1'b1;
      @(negedge clk); idle_req_vld = 1'b0; wake_evt = 1'b0;
      settle();
      nxp = 0; add_exp(11); add_exp(10);
      cmp_log("R12");
      chk(cur_level == 0, "R12", "wake beats request", int'(cur_level), 0);

      // R7 wake while flush is pending
      nev = 0;
      do_req(4);
      begin
         int g;
         g = 0;
         while (!flush_req && g < 500) begin @(negedge clk); g++; end
      end
      wake_pulse(); settle();
      nxp = 0; add_exp(11); add_exp(12); add_exp(13); add_exp(20); add_exp(12); add_exp(11); add_exp(10);
      cmp_log("R7");
      chk(cur_level == 0 && !clk_halt && clk_code == 0, "R7", "unwound to active", int'(cur_level), 0);

      // R7 wake during the first clock step
      nev = 0;
      do_req(3);
      wake_pulse(); settle();
      nxp = 0; add_exp(11); add_exp(10);
      cmp_log("R7");
      chk(cur_level == 0, "R7", "abort after first step", int'(cur_level), 0);

      // R10 request while busy is ignored
      nev = 0;
      do_req(4);
      do_req(1);
      settle();
      build_exp(0, 6);
      cmp_log("R10");
      chk(cur_level == 4, "R10", "level after busy request", int'(cur_level), 4);
      wake_pulse(); settle();

      // R11 handshake timeout on the flush
      dly_fl = 200;
      nev = 0;
      do_req(3);
      begin
         int g;
         g = 0;
         while (!flush_req && g < 500) begin @(negedge clk); g++; end
      end
      repeat (LIM - 2) @(negedge clk);
      chk(!hs_error && flush_req, "R11", "error before limit", int'(hs_error), 0);
      repeat (6) @(negedge clk);
      chk(hs_error, "R11", "error after limit", int'(hs_error), 1);
      chk(cur_level == 0 && !busy, "R11", "level after timeout", int'(cur_level), 0);
      chk(!clk_halt && clk_code == 0 && !volt_low && !flush_req, "R11", "outputs active", int'(clk_code), 0);
      dly_fl = 3;
      do_req(1); settle();
      chk(!hs_error && cur_level == 1, "R11", "error cleared by accepted request", int'(hs_error), 0);
      wake_pulse(); settle();

      chk(overlap == 0, "R6", "cycles with two requests", overlap, 0);

      summary();
      $finish;
   end

endmodule